// File: doc/BRIEF.md
# Carry-Select Compound Adder

This is a purely combinational adder for two unsigned operands of equal width. It returns two results together: the plain sum and the sum plus one. Logic that needs both values, such as a rounding step that picks between a truncated result and its increment, gets them from one structure and does not need a second adder.

The operand width is cut into consecutive sub-blocks. Each sub-block forms its local sum twice, once with carry-in 0 and once with carry-in 1, and gives a carry-out for each case. Two select chains run across the blocks. One chain starts at carry 0 and produces the plain sum. The other starts at carry 1 and produces the incremented sum. At each block, a chain takes the carry-out of the block below it and uses it to pick the local pair. A build parameter sets the partition. The default is one block spanning the full width. The other choice is 4-bit blocks, where the least significant block is narrowed to take up any remainder.

Top module: `cs_compound_adder`

## Requirements
- R1: `sum_o` equals a_i + b_i as unsigned values, zero-extended to WIDTH+1 bits, for every operand pair.
- R2: `sum1_o` equals a_i + b_i + 1 as unsigned values in WIDTH+1 bits, for every operand pair.
- R3: Bit WIDTH of each output holds the final carry-out. With both operands all ones, `sum_o` is 2^(WIDTH+1)-2 and `sum1_o` is 2^(WIDTH+1)-1.
- R4: With both operands zero, `sum_o` is 0 and `sum1_o` is 1.
- R5: With SPLIT = SPLIT_WHOLE (the default), one sub-adder spans the full width and R1 and R2 hold.
- R6: With SPLIT = SPLIT_QUAD, the width is cut into 4-bit blocks, the lowest block having WIDTH mod 4 bits when that is non-zero. A carry travels correctly through every block boundary: a_i all ones with b_i = 0 gives `sum_o` = 2^WIDTH-1 and `sum1_o` = 2^WIDTH.
- R7: For every input, `sum1_o` equals `sum_o` + 1 in WIDTH+1 bits, and at every block boundary the carry of the plain chain is never 1 while the carry of the incremented chain is 0.
- R8: The outputs depend only on the present operands. No clock, and no input history, changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | A_W | First unsigned operand |
| b_i | input | B_W | Second unsigned operand (B_W must equal A_W) |
| sum_o | output | A_W+1 | a_i + b_i including the carry-out |
| sum1_o | output | A_W+1 | a_i + b_i + 1 including the carry-out |

## Verification
The bench builds both partitions at a width of 10, which leaves a 2-bit lowest block in the 4-bit mode, and drives the same operands into both.

Each corner case targets a specific kind of fault:
- All ones plus zero sends a carry through every block boundary. A select chain that feeds a block from the wrong neighbour, or that inverts the carry, would damage the upper bits of `sum1_o`.
- All ones plus all ones would expose a result truncated to the operand width.
- Operands that straddle the narrow lowest block would expose a mis-placed block offset, which shows up as shifted or duplicated bits.
- Zero operands would show a chain that seeds `sum1_o` with the wrong carry.

// File: rtl/cs_add_pkg.sv
package cs_add_pkg;

  typedef enum logic [0:0] {
    SPLIT_WHOLE = 1'b0,
    SPLIT_QUAD  = 1'b1
  } split_e;

  localparam int unsigned QUAD_W = 4;

  function automatic int unsigned blk_count(int unsigned w, split_e mode);
    return (mode == SPLIT_QUAD) ? (w + QUAD_W - 1) / QUAD_W : 1;
  endfunction

  // lowest block absorbs the remainder
  function automatic int unsigned low_width(int unsigned w, split_e mode);
    return w - QUAD_W * (blk_count(w, mode) - 1);
  endfunction

  function automatic int unsigned blk_lsb(int unsigned w, split_e mode, int unsigned idx);
    return (idx == 0) ? 0 : low_width(w, mode) + QUAD_W * (idx - 1);
  endfunction

  function automatic int unsigned blk_width(int unsigned w, split_e mode, int unsigned idx);
    return (idx == 0) ? low_width(w, mode) : QUAD_W;
  endfunction

endpackage

// File: rtl/cs_add_blk.sv
module cs_add_blk #(
  parameter int unsigned BW = 4
) (
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [BW-1:0] s0_o,
  output logic [BW-1:0] s1_o,
  output logic          co0_o,
  output logic          co1_o
);

  logic [BW:0] ext_a, ext_b, t0, t1;

  always_comb begin
    ext_a = {1'b0, a_i};
    ext_b = {1'b0, b_i};
    t0    = ext_a + ext_b;
    t1    = ext_a + ext_b + (BW+1)'(1);
  end

  assign {co0_o, s0_o} = t0;
  assign {co1_o, s1_o} = t1;

  // R7
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      carry_dom_chk: assert (!(co0_o && !co1_o))
        else $error("block carry-in 0 produced carry while carry-in 1 did not");
    end
  end

endmodule

// File: rtl/cs_add_chain.sv
module cs_add_chain #(
  parameter int unsigned NB = 1
) (
  input  logic          cin_i,
  input  logic [NB-1:0] co0_i,
  input  logic [NB-1:0] co1_i,
  output logic [NB:0]   c_o
);

  logic [NB:0] c;

  assign c[0] = cin_i;

  for (genvar i = 0; i < NB; i++) begin : gen_sel
    assign c[i+1] = c[i] ? co1_i[i] : co0_i[i];
  end

  assign c_o = c;

endmodule

// File: rtl/cs_compound_adder.sv
module cs_compound_adder
  import cs_add_pkg::*;
#(
  parameter int unsigned A_W   = 16,
  parameter int unsigned B_W   = 16,
  parameter split_e      SPLIT = SPLIT_WHOLE
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [A_W:0]   sum_o,
  output logic [A_W:0]   sum1_o
);

  localparam int unsigned W  = A_W;
  localparam int unsigned NB = blk_count(W, SPLIT);

  if (A_W != B_W) begin : gen_width_err
    $error("operand widths differ");
  end

  logic [W-1:0]  s0_all, s1_all, res_lo, res_hi;
  logic [NB-1:0] co0_all, co1_all;
  logic [NB:0]   c_lo, c_hi;

  for (genvar i = 0; i < NB; i++) begin : gen_blk
    localparam int unsigned LSB = blk_lsb(W, SPLIT, i);
    localparam int unsigned BW  = blk_width(W, SPLIT, i);

    cs_add_blk #(.BW(BW)) u_blk (
      .a_i   (a_i[LSB +: BW]),
      .b_i   (b_i[LSB +: BW]),
      .s0_o  (s0_all[LSB +: BW]),
      .s1_o  (s1_all[LSB +: BW]),
      .co0_o (co0_all[i]),
      .co1_o (co1_all[i])
    );

    assign res_lo[LSB +: BW] = c_lo[i] ? s1_all[LSB +: BW] : s0_all[LSB +: BW];
    assign res_hi[LSB +: BW] = c_hi[i] ? s1_all[LSB +: BW] : s0_all[LSB +: BW];
  end

  cs_add_chain #(.NB(NB)) u_chain_lo (
    .cin_i (1'b0),
    .co0_i (co0_all),
    .co1_i (co1_all),
    .c_o   (c_lo)
  );

  cs_add_chain #(.NB(NB)) u_chain_hi (
    .cin_i (1'b1),
    .co0_i (co0_all),
    .co1_i (co1_all),
    .c_o   (c_hi)
  );

  assign sum_o  = {c_lo[NB], res_lo};
  assign sum1_o = {c_hi[NB], res_hi};

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R7
      sum_step_chk: assert (sum1_o == sum_o + (W+1)'(1))
        else $error("sum1 is not sum plus one");
      // R7
      chain_order_chk: assert ((c_lo & ~c_hi) == '0)
        else $error("plain chain carries where incremented chain does not");
      // R4
      zero_in_chk: assert (!((a_i == '0) && (b_i == '0)) || (sum_o == '0 && sum1_o == (W+1)'(1)))
        else $error("zero operands gave wrong results");
      // R3
      ones_chk: assert (!((&a_i) && (&b_i)) || (&sum1_o))
        else $error("all-ones operands lost the carry-out");
    end
  end

endmodule

// File: tb/cs_compound_adder_tb.sv
module cs_compound_adder_tb;
  import cs_add_pkg::*;

  localparam int unsigned W = 10;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [W:0]   s_w, s1_w, s_q, s1_q;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done  = 1'b0;

  always #2 clk = ~clk;

  cs_compound_adder #(.A_W(W), .B_W(W)) u_dut (
    .a_i(a), .b_i(b), .sum_o(s_w), .sum1_o(s1_w)
  );

  cs_compound_adder #(.A_W(W), .B_W(W), .SPLIT(SPLIT_QUAD)) u_dut_q4 (
    .a_i(a), .b_i(b), .sum_o(s_q), .sum1_o(s1_q)
  );

  function automatic logic [W:0] ref_sum(logic [W-1:0] x, logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [W:0] ref_sum1(logic [W-1:0] x, logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y} + (W+1)'(1);
  endfunction

  task automatic check(string tag, logic [W:0] got, logic [W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s a=%h b=%h got=%h exp=%h", tag, a, b, got, exp);
    end
  endtask

  // drive after falling edge, sample 1 ns later (combinational)
  task automatic apply(logic [W-1:0] x, logic [W-1:0] y);
    @(negedge clk);
    a = x;
    b = y;
    #1;
  endtask

  task automatic check_all(string tag);
    check({tag, " R1 R5 whole sum"},  s_w,  ref_sum(a, b));
    check({tag, " R2 R5 whole sum1"}, s1_w, ref_sum1(a, b));
    check({tag, " R1 R6 quad sum"},   s_q,  ref_sum(a, b));
    check({tag, " R2 R6 quad sum1"},  s1_q, ref_sum1(a, b));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20250129);
    a = '0;
    b = '0;
    #1;
    // R4 initial / zero state
    check("R4 zero sum whole",  s_w,  '0);
    check("R4 zero sum1 whole", s1_w, (W+1)'(1));
    check("R4 zero sum quad",   s_q,  '0);
    check("R4 zero sum1 quad",  s1_q, (W+1)'(1));

    // R3 all ones + all ones
    apply('1, '1);
    check("R3 ones sum whole",  s_w,  {1'b1, {(W-1){1'b1}}, 1'b0});
    check("R3 ones sum1 whole", s1_w, '1);
    check("R3 ones sum quad",   s_q,  {1'b1, {(W-1){1'b1}}, 1'b0});
    check("R3 ones sum1 quad",  s1_q, '1);

    // R6 full propagate through every block boundary
    apply('1, '0);
    check("R6 prop sum quad",   s_q,  {1'b0, {W{1'b1}}});
    check("R6 prop sum1 quad",  s1_q, {1'b1, {W{1'b0}}});
    check("R5 prop sum1 whole", s1_w, {1'b1, {W{1'b0}}});

    // R6 boundary of the 2-bit lowest block
    apply(10'h003, 10'h001);
    check_all("R6 low edge");
    apply(10'h03f, 10'h001);
    check_all("R6 mid edge");
    apply(10'h2aa, 10'h155);
    check_all("R6 alt");
    apply(10'h200, 10'h200);
    check_all("R3 top carry");

    // R8 same operands after idle cycles give the same results
    apply(10'h123, 10'h0ff);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R8 hold sum", s_q,  ref_sum(10'h123, 10'h0ff));
    check("R8 hold sum1", s1_w, ref_sum1(10'h123, 10'h0ff));

    for (int i = 0; i < 400; i++) begin
      apply(W'($urandom), W'($urandom));
      check_all("R1 R2 rand");
      // R7 relation between outputs
      check("R7 step quad", s1_q, s_q + (W+1)'(1));
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule